// File: doc/BRIEF.md
# Ones-Complement Tick Waiter

This unit holds a single requester until a programmed number of slow clock ticks have passed. The requester gives an 18-bit operand with a one-cycle request strobe. All arithmetic on the operand is ones-complement. A zero or positive operand needs no waiting, so the request completes at once and the operand comes back unchanged. A negative operand is loaded into a count register. On each slow tick the unit adds one to that count in ones-complement form. When the count reaches zero, the requester is released.

The slow tick comes from a reference enable input through a prescaler. The prescaler divides by the ratio of the reference rate to 1760 ticks per minute, which is about 29.3 Hz. The prescaler restarts whenever a request is accepted. Because of this, the wait is measured in whole tick periods counted from the request. The longest single wait is 2^17 - 1 ticks, a little over 74 minutes. While a wait is pending, the `hang` output stays high. At completion, `done` pulses for one cycle and `result` carries the final count.

Top module: `oc_tick_wait`

## Requirements
- R1: After reset, `hang` and `done` are low and `result` is all zeros.
- R2: An accepted request whose operand has bit 17 clear (zero or positive) never raises `hang`. One cycle later `done` pulses and `result` equals the operand.
- R3: An accepted request whose operand is minus zero (all ones, 18'o777777) completes in the same way, and `result` returns 18'o777777.
- R4: An accepted request whose operand has bit 17 set and is not all ones raises `hang` in the next cycle.
- R5: While `hang` is high, each slow tick adds one to the count with end-around carry. Release therefore follows exactly m ticks, where m is the bitwise complement of the operand.
- R6: On release, `hang` falls, `done` is high for exactly that one cycle, and `result` is plus zero (all zeros).
- R7: One slow tick occurs per DIV reference enables, with DIV = REF_PER_MIN / 1760 (default 4). The prescaler restarts when a request is accepted, so a negative operand waits exactly m*DIV reference enables, counted from the accepting edge.
- R8: A request strobe that arrives while `hang` is high is ignored. It does not change the wait length or the returned result.
- R9: `result` does not change except at a completion, including while waiting and while idle with reference enables present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, one cycle |
| req_val | input | 18 | Ones-complement operand given with the request |
| ref_en | input | 1 | Reference enable that feeds the prescaler |
| hang | output | 1 | High while the requester is held |
| done | output | 1 | One-cycle completion pulse |
| result | output | 18 | Final count, valid from the completion cycle on |

## Verification
The assertions assume that `req` is a single-cycle strobe sampled at the clock and that `req_val` is stable in the cycle it is sampled. They relate the operand class seen at an accepted request to `hang`, `done` and `result` one cycle later. The stimulus drives every input at the falling edge, so each value is settled before the rising edge that samples it. It holds `req` high for one cycle only, including when it injects a strobe in the middle of a wait. Reference enables are given continuously in some tests and in a gapped pattern in others. The bench counts the enables that actually fall within the wait, and its expected wait length comes from that count.

// File: rtl/oc_wait_pkg.sv
package oc_wait_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HANG = 1'b1
  } wait_state_e;

  localparam int unsigned TICKS_PER_MINUTE = 1760;

endpackage

// File: rtl/oc_wait_incr.sv
// Ones-complement add-one with end-around carry and a zero detector that
// recognises both representations of zero.
module oc_wait_incr #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] sum,
  output logic         zero_hit
);

  logic [W:0] raw;

  always_comb begin
    raw      = {1'b0, val} + {{W{1'b0}}, 1'b1};
    sum      = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    zero_hit = (sum == '0) || (&sum);
  end

endmodule

// File: rtl/oc_wait_prescaler.sv
// Divides a reference enable by DIV; restartable.
module oc_wait_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic ref_en,
  output logic tick
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    tick    = ref_en && at_last && !clear;
    cnt_d   = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (ref_en) begin
      cnt_d = at_last ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/oc_tick_wait.sv
module oc_tick_wait
  import oc_wait_pkg::*;
#(
  parameter int unsigned W           = 18,
  parameter int unsigned REF_PER_MIN = 7040
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] req_val,
  input  logic         ref_en,
  output logic         hang,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int unsigned DIV = REF_PER_MIN / TICKS_PER_MINUTE;

  wait_state_e  state_q, state_d;
  logic [W-1:0] count_q, count_d;
  logic [W-1:0] result_q, result_d;
  logic         done_q, done_d;
  logic         accept, tick, op_neg, op_mzero;
  logic [W-1:0] inc_sum;
  logic         inc_zero;

  oc_wait_prescaler #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .ref_en (ref_en),
    .tick   (tick)
  );

  oc_wait_incr #(.W(W)) u_incr (
    .val      (count_q),
    .sum      (inc_sum),
    .zero_hit (inc_zero)
  );

  always_comb begin
    accept   = req && (state_q == ST_IDLE);
    op_neg   = req_val[W-1];
    op_mzero = &req_val;
    state_d  = state_q;
    count_d  = count_q;
    result_d = result_q;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (op_neg && !op_mzero) begin
            count_d = req_val;
            state_d = ST_HANG;
          end else begin
            result_d = req_val;
            done_d   = 1'b1;
          end
        end
      end
      ST_HANG: begin
        if (tick) begin
          count_d = inc_sum;
          if (inc_zero) begin
            state_d  = ST_IDLE;
            result_d = '0;
            done_d   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      count_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      count_q  <= count_d;
      result_q <= result_d;
      done_q   <= done_d;
    end
  end

  assign hang   = (state_q == ST_HANG);
  assign done   = done_q;
  assign result = result_q;

endmodule

// File: rtl/oc_tick_wait_chk.sv
module oc_tick_wait_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req,
  input logic [W-1:0] req_val,
  input logic         hang,
  input logic         done,
  input logic [W-1:0] result
);

  assert_nonneg_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hang && !req_val[W-1]) |=> (done && !hang && result == $past(req_val)));

  assert_minus_zero_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hang && (&req_val)) |=> (done && !hang && (&result)));

  assert_negative_hangs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hang && req_val[W-1] && !(&req_val)) |=> (hang && !done));

  assert_release_plus_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hang) |-> (done && result == '0));

  assert_done_not_hanging_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hang);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

bind oc_tick_wait oc_tick_wait_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .req_val (req_val),
  .hang    (hang),
  .done    (done),
  .result  (result)
);

// File: tb/test_oc_tick_wait.sv
module test_oc_tick_wait;

  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [17:0] req_val = '0;
  logic        ref_en = 1'b0;
  logic        hang, done;
  logic [17:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  oc_tick_wait i_oc_tick_wait (
    .clk(clk), .rst_n(rst_n), .req(req), .req_val(req_val),
    .ref_en(ref_en), .hang(hang), .done(done), .result(result)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    check("R1 hang", {31'd0, hang}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 result", {14'd0, result}, 32'd0);
  endtask

  // immediate completion for non-negative or minus-zero operands
  task automatic t_immediate(input logic [17:0] v, input string tag);
    @(negedge clk); req = 1'b1; req_val = v;
    @(negedge clk); req = 1'b0;
    check({tag, " done"}, {31'd0, done}, 32'd1);
    check({tag, " hang"}, {31'd0, hang}, 32'd0);
    check({tag, " result"}, {14'd0, result}, {14'd0, v});
    @(negedge clk);
    check({tag, " done single"}, {31'd0, done}, 32'd0);
  endtask

  // negative operand; gap=1 gives ref_en on alternate cycles; inject=1 strobes req mid-wait
  task automatic t_wait(input int m, input bit gap, input bit inject, input string tag);
    int pulses = 0;
    int cycles = 0;
    @(negedge clk); req = 1'b1; req_val = ~18'(m); ref_en = 1'b1;
    @(negedge clk); req = 1'b0;
    check({tag, " R4 hang rises"}, {31'd0, hang}, 32'd1);
    while (hang && cycles < 5000) begin
      ref_en = gap ? cycles[0] : 1'b1;
      req    = inject && (cycles == 2);
      req_val = 18'o000123;
      pulses += int'(ref_en);
      cycles++;
      @(negedge clk);
    end
    req = 1'b0; ref_en = 1'b0;
    check({tag, " R7 ref enables in wait"}, pulses, m * DIV);
    if (!gap) check({tag, " R5 wait cycles"}, cycles, m * DIV);
    check({tag, " R6 done"}, {31'd0, done}, 32'd1);
    check({tag, " R6 result plus zero"}, {14'd0, result}, 32'd0);
    @(negedge clk);
    check({tag, " R6 done single"}, {31'd0, done}, 32'd0);
  endtask

  task automatic t_hold();
    logic [17:0] r0;
    r0 = result;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); ref_en = 1'b1;
    end
    @(negedge clk); ref_en = 1'b0;
    check("R9 result held idle", {14'd0, result}, {14'd0, r0});
  endtask

  task automatic t_restart();
    // partial prescaler progress while idle must not shorten the next wait
    @(negedge clk); ref_en = 1'b1;
    @(negedge clk);
    @(negedge clk); ref_en = 1'b0;
    t_wait(1, 1'b0, 1'b0, "R7 restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate(18'o000000, "R2 plus zero");
    t_immediate(18'o000001, "R2 one");
    t_immediate(18'o377777, "R2 max positive");
    t_immediate(18'o777777, "R3 minus zero");
    t_wait(1, 1'b0, 1'b0, "R5 m1");
    t_wait(2, 1'b0, 1'b0, "R5 m2");
    t_wait(5, 1'b0, 1'b0, "R5 m5");
    t_wait(40, 1'b0, 1'b0, "R5 m40");
    t_wait(3, 1'b1, 1'b0, "R7 gapped");
    t_wait(4, 1'b0, 1'b1, "R8 ignored req");
    t_immediate(18'o000456, "R2 after wait");
    t_hold();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule